// File: doc/BRIEF.md
# Serial Shift Slice with Shadow Exchange

This block is one serial shift lane. A working data register shifts right by one bit at a programmable rate. The serial input enters at the top bit, and the serial output is taken from the bottom bit. A clock-division down counter sets the rate. It reloads from a preset value, so a shift happens once every preset+1 clock cycles. A second down counter tracks the position within a frame. When that counter expires, the working register and a shadow register trade contents. Software can then read or refill one frame while the next frame is being shifted.

All settings are loaded through a single-cycle write port: a 3-bit select plus a data word. The slice starts counting after a write-one to the start code and halts after a write-one to the stop code. A shift strobe and an exchange strobe are driven out for an interrupt block. The block is controlled by a two-state run machine. `ST_IDLE` moves to `ST_RUN` on a start write with bit 0 set. `ST_RUN` moves to `ST_IDLE` on a stop write with bit 0 set. Every other input keeps the current state.

Top module: `shift_slice`

## Requirements
- R1: While running, the division counter decrements by one each cycle. In a cycle where it is zero, it loads the preset value on the next edge and does not wrap.
- R2: The position word holds the current position in bits 7:0 and its reload value in bits 15:8. In each cycle where the division counter is zero, the current position decrements by one, or loads the reload value if it is already zero.
- R3: In each running cycle where the division counter is zero, the working register shifts right by one bit and `ser_in` enters at bit 31. `ser_out` always equals bit 0 of the working register.
- R4: In a shift cycle where the current position is zero, the working register loads the old shadow value. In the same cycle, the shadow register loads the working value shifted with `ser_in`.
- R5: `shift_stb` is high exactly in the shift cycles. `exch_stb` is high exactly in the exchange cycles. Both strobes stay low while the slice is stopped.
- R6: A write of code 5 with `wr_data[0]`=1 starts the slice. A write of code 6 with `wr_data[0]`=1 stops it. Either code written with bit 0 clear leaves `run_q` unchanged.
- R7: A register write in the same cycle as a count, shift or exchange wins for the register it targets. The other registers still update.
- R8: While stopped, the working register, shadow register, counter and position word keep their values unless they are written.
- R9: Reset clears every register and leaves the slice stopped.
- R10: The write codes are 0 for working data, 1 for shadow data, 2 for preset (`wr_data[11:0]`), 3 for the division counter (`wr_data[11:0]`) and 4 for the position word (`wr_data[15:0]`). Code 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target code |
| wr_data | input | 32 | Write data |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out (working bit 0) |
| shift_stb | output | 1 | One-cycle pulse per shift |
| exch_stb | output | 1 | One-cycle pulse per exchange |
| work_q | output | 32 | Working register |
| shadow_q | output | 32 | Shadow register |
| cnt_q | output | 12 | Division counter |
| pos_q | output | 16 | Position word {reload, current} |
| run_q | output | 1 | Slice running |

## Verification
The bench builds the block with its defaults: 32 data bits, a 12-bit division counter and 8-bit positions. The bench limits preset, counter and position values to 0 to 3. With values that small, shifts, exchanges and reloads happen often. Preset 0 combined with reload 0 produces an exchange every cycle. That setting places writes, start and stop directly on top of exchanges and pins down the R7 priority cases.

// File: rtl/shift_slice_pkg.sv
package shift_slice_pkg;
    typedef enum logic [2:0] {
        SEL_WORK   = 3'd0,
        SEL_SHADOW = 3'd1,
        SEL_PRESET = 3'd2,
        SEL_COUNT  = 3'd3,
        SEL_POS    = 3'd4,
        SEL_START  = 3'd5,
        SEL_STOP   = 3'd6,
        SEL_NONE   = 3'd7
    } wr_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/shift_div_ctr.sv
module shift_div_ctr #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ld_pre,
    input  logic             ld_cnt,
    input  logic [CNT_W-1:0] wr_val,
    output logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] pre_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else begin
            if (ld_pre)
                pre_q <= wr_val;
            if (ld_cnt)
                cnt_q <= wr_val;
            else if (run)
                cnt_q <= (cnt_q == '0) ? pre_q : cnt_q - ONE;
        end
    end
endmodule

// File: rtl/shift_pos_ctr.sv
module shift_pos_ctr #(
    parameter int POS_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               ld,
    input  logic [2*POS_W-1:0] wr_word,
    output logic               wrap,
    output logic [2*POS_W-1:0] pos_word
);
    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    logic [POS_W-1:0] cur_q;
    logic [POS_W-1:0] rld_q;

    assign wrap     = tick && (cur_q == '0);
    assign pos_word = {rld_q, cur_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            rld_q <= '0;
        end else if (ld) begin
            cur_q <= wr_word[POS_W-1:0];
            rld_q <= wr_word[2*POS_W-1:POS_W];
        end else if (tick) begin
            cur_q <= (cur_q == '0) ? rld_q : cur_q - ONE;
        end
    end
endmodule

// File: rtl/shift_data_pair.sv
module shift_data_pair #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic              swap,
    input  logic              ser_in,
    input  logic              ld_work,
    input  logic              ld_shadow,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] work_q,
    output logic [DATA_W-1:0] shadow_q
);
    logic [DATA_W-1:0] shifted;

    assign shifted = {ser_in, work_q[DATA_W-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q   <= '0;
            shadow_q <= '0;
        end else begin
            if (ld_work)
                work_q <= wr_data;
            else if (swap)
                work_q <= shadow_q;
            else if (shift)
                work_q <= shifted;

            if (ld_shadow)
                shadow_q <= wr_data;
            else if (swap)
                shadow_q <= shifted;
        end
    end
endmodule

// File: rtl/shift_slice.sv
module shift_slice
    import shift_slice_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12,
    parameter int POS_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               ser_in,
    output logic               ser_out,
    output logic               shift_stb,
    output logic               exch_stb,
    output logic [DATA_W-1:0]  work_q,
    output logic [DATA_W-1:0]  shadow_q,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [2*POS_W-1:0] pos_q,
    output logic               run_q
);
    localparam int PW = 2 * POS_W;

    run_state_e state_q, state_d;
    wr_sel_e    sel;
    logic       run, tick, wrap;
    logic       ld_work, ld_shadow, ld_pre, ld_cnt, ld_pos, go, halt;
    logic [CNT_W-1:0] preset_q;

    assign sel = wr_sel_e'(wr_sel);

    // Write decode
    always_comb begin
        ld_work   = 1'b0;
        ld_shadow = 1'b0;
        ld_pre    = 1'b0;
        ld_cnt    = 1'b0;
        ld_pos    = 1'b0;
        go        = 1'b0;
        halt      = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_WORK:   ld_work   = 1'b1;
                SEL_SHADOW: ld_shadow = 1'b1;
                SEL_PRESET: ld_pre    = 1'b1;
                SEL_COUNT:  ld_cnt    = 1'b1;
                SEL_POS:    ld_pos    = 1'b1;
                SEL_START:  go        = wr_data[0];
                SEL_STOP:   halt      = wr_data[0];
                SEL_NONE:   ;
            endcase
        end
    end

    // Run-state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go)   state_d = ST_RUN;
            ST_RUN:  if (halt) state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_IDLE: run = 1'b0;
            ST_RUN:  run = 1'b1;
        endcase
    end

    assign run_q     = run;
    assign shift_stb = tick;
    assign exch_stb  = wrap;
    assign ser_out   = work_q[0];

    shift_div_ctr #(.CNT_W(CNT_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .ld_pre (ld_pre),
        .ld_cnt (ld_cnt),
        .wr_val (wr_data[CNT_W-1:0]),
        .tick   (tick),
        .cnt_q  (cnt_q),
        .pre_q  (preset_q)
    );

    shift_pos_ctr #(.POS_W(POS_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ld       (ld_pos),
        .wr_word  (wr_data[PW-1:0]),
        .wrap     (wrap),
        .pos_word (pos_q)
    );

    shift_data_pair #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift     (tick),
        .swap      (wrap),
        .ser_in    (ser_in),
        .ld_work   (ld_work),
        .ld_shadow (ld_shadow),
        .wr_data   (wr_data),
        .work_q    (work_q),
        .shadow_q  (shadow_q)
    );
endmodule

// File: rtl/shift_slice_chk.sv
module shift_slice_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12,
    parameter int POS_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               shift_stb,
    input logic               exch_stb,
    input logic               run_q,
    input logic [DATA_W-1:0]  work_q,
    input logic [DATA_W-1:0]  shadow_q,
    input logic [CNT_W-1:0]   cnt_q,
    input logic [CNT_W-1:0]   preset_q,
    input logic [2*POS_W-1:0] pos_q
);
    // R5: an exchange only happens on a shift
    a_r5_exch_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
        exch_stb |-> shift_stb);

    // R5: quiet strobes while stopped
    a_r5_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !shift_stb);

    // R1: decrement when nonzero
    a_r1_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !wr_en && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

    // R1: reload from preset at zero
    a_r1_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb && !wr_en) |=> cnt_q == $past(preset_q));

    // R4: working register takes old shadow on exchange
    a_r4_swap_in: assert property (@(posedge clk) disable iff (!rst_n)
        (exch_stb && !wr_en) |=> work_q == $past(shadow_q));

    // R8: stopped and unwritten state holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_en) |=> ($stable(work_q) && $stable(shadow_q)
                                && $stable(cnt_q) && $stable(pos_q)));
endmodule

bind shift_slice shift_slice_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .shift_stb (shift_stb),
    .exch_stb  (exch_stb),
    .run_q     (run_q),
    .work_q    (work_q),
    .shadow_q  (shadow_q),
    .cnt_q     (cnt_q),
    .preset_q  (preset_q),
    .pos_q     (pos_q)
);

// File: tb/shift_slice_tb_top.sv
`timescale 1ns/1ps
module shift_slice_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd7;
    logic [31:0] wr_data = '0;
    logic        ser_in = 1'b0;
    logic        ser_out, shift_stb, exch_stb, run_q;
    logic [31:0] work_q, shadow_q;
    logic [11:0] cnt_q;
    logic [15:0] pos_q;

    int checks = 0;
    int failures = 0;
    string ctx = "";

    // model state
    logic [31:0] m_work = '0, m_sh = '0;
    logic [11:0] m_cnt = '0, m_pre = '0;
    logic [7:0]  m_cur = '0, m_rld = '0;
    logic        m_run = 1'b0;

    always #2 clk = ~clk;

    shift_slice dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ser_in(ser_in), .ser_out(ser_out),
        .shift_stb(shift_stb), .exch_stb(exch_stb), .work_q(work_q),
        .shadow_q(shadow_q), .cnt_q(cnt_q), .pos_q(pos_q), .run_q(run_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, ctx, act, exp);
        end
    endtask

    function automatic logic [31:0] shifted(input logic [31:0] w, input logic si);
        return {si, w[31:1]};
    endfunction

    task automatic cyc(input logic [2:0] s, input logic e, input logic [31:0] d, input logic si);
        logic tk, wp;
        logic [31:0] n_work, n_sh;
        logic [11:0] n_cnt, n_pre;
        logic [7:0]  n_cur, n_rld;
        logic        n_run;
        @(negedge clk);
        wr_sel = s; wr_en = e; wr_data = d; ser_in = si;
        #0.5;
        tk = m_run && (m_cnt == 12'd0);
        wp = tk && (m_cur == 8'd0);
        chk("R5 shift_stb", {31'd0, shift_stb}, {31'd0, tk});
        chk("R5 exch_stb", {31'd0, exch_stb}, {31'd0, wp});
        chk("R3 ser_out", {31'd0, ser_out}, {31'd0, m_work[0]});
        chk("R4 work_q", work_q, m_work);
        chk("R4 shadow_q", shadow_q, m_sh);
        chk("R1 cnt_q", {20'd0, cnt_q}, {20'd0, m_cnt});
        chk("R2 pos_q", {16'd0, pos_q}, {16'd0, m_rld, m_cur});
        chk("R6 run_q", {31'd0, run_q}, {31'd0, m_run});
        n_work = m_work; n_sh = m_sh; n_cnt = m_cnt; n_pre = m_pre;
        n_cur = m_cur; n_rld = m_rld; n_run = m_run;
        if (m_run) n_cnt = (m_cnt == 12'd0) ? m_pre : m_cnt - 12'd1;
        if (tk) n_cur = (m_cur == 8'd0) ? m_rld : m_cur - 8'd1;
        if (wp) begin
            n_work = m_sh; n_sh = shifted(m_work, si);
        end else if (tk) n_work = shifted(m_work, si);
        if (e) begin
            case (s)
                3'd0: n_work = d;
                3'd1: n_sh = d;
                3'd2: n_pre = d[11:0];
                3'd3: n_cnt = d[11:0];
                3'd4: begin n_rld = d[15:8]; n_cur = d[7:0]; end
                3'd5: if (d[0]) n_run = 1'b1;
                3'd6: if (d[0]) n_run = 1'b0;
                default: ;
            endcase
        end
        @(posedge clk);
        m_work = n_work; m_sh = n_sh; m_cnt = n_cnt; m_pre = n_pre;
        m_cur = n_cur; m_rld = n_rld; m_run = n_run;
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        cyc(s, 1'b1, d, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(3'd7, 1'b0, 32'd0, i[0]);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4021));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        ctx = "R9 reset";
        idle(2);

        // R10 register loads and R6 start
        ctx = "R10 load";
        wr(3'd0, 32'hA5A5_3C3C);
        wr(3'd1, 32'h1234_5678);
        wr(3'd2, 32'd2);
        wr(3'd4, 32'h0000_0303);
        wr(3'd7, 32'hFFFF_FFFF);
        ctx = "R6 start";
        wr(3'd5, 32'd0);
        wr(3'd5, 32'd1);
        ctx = "R1 R2 R3 R4 run";
        for (int i = 0; i < 40; i++) cyc(3'd7, 1'b0, 32'd0, i[1] ^ i[0]);

        // R8 hold while stopped
        ctx = "R6 stop";
        wr(3'd6, 32'd0);
        wr(3'd6, 32'd1);
        ctx = "R8 hold";
        idle(12);

        // R7 priority: exchange every cycle, writes land on exchanges
        ctx = "R7 priority";
        wr(3'd2, 32'd0);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd0);
        wr(3'd5, 32'd1);
        idle(3);
        wr(3'd0, 32'hDEAD_BEEF);
        wr(3'd1, 32'hCAFE_F00D);
        wr(3'd3, 32'd3);
        idle(4);
        wr(3'd4, 32'h0000_0100);
        idle(6);

        // random phase
        ctx = "random";
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] s;
            logic [31:0] d;
            logic e;
            e = ($urandom % 6) == 0;
            s = 3'($urandom % 8);
            if (s == 3'd6 && ($urandom % 4) != 0) s = 3'd5;
            d = $urandom;
            if (s == 3'd2 || s == 3'd3) d = d & 32'd3;
            if (s == 3'd4) d = d & 32'h0000_0303;
            cyc(s, e, d, 1'($urandom));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule